// File: doc/BRIEF.md
# Extended Control Register Access Unit

This block handles reads and writes of the extended-state enable register. That register selects which groups of processor state a context-save operation may cover. A request arrives as a single-cycle strobe together with a read/write select, a 32-bit register index, a 64-bit write value, the operating-system enable bit and the 64-bit mask of supported state components. The mask arrives as two 32-bit halves.

Every request is screened by an ordered series of checks before anything else happens. The first check is the operating-system enable bit, then the register index, then the rule that x87 state must stay enabled, and last the supported-feature mask. A request that fails produces exactly one fault indication. A read that passes returns either the enable register or the enable register masked by the in-use vector, depending on the index. A write that passes replaces the whole register. Every request is answered by one registered done pulse in the following cycle.

Top module: `xcr_access_unit`

## Requirements
- R1: After reset the enable register holds 64'h1. All outputs are zero until the first request has been answered.
- R2: When `os_enable` is 0, a request of either kind asserts `rsp_ud_fault`, leaves `rsp_gp_fault` low and returns zero data. The enable register keeps its value.
- R3: A read with index 0 returns the full 64-bit enable register on `rsp_rdata` and asserts no fault.
- R4: A read with index 1 returns the enable register ANDed with the in-use vector. The in-use vector is all ones, so the value equals the enable register.
- R5: A read with any index other than 0 or 1 asserts `rsp_gp_fault` and returns zero data.
- R6: A write with a nonzero index asserts `rsp_gp_fault` and leaves the enable register unchanged.
- R7: A write whose value has bit 0 (x87 state) at 0 asserts `rsp_gp_fault` and leaves the enable register unchanged.
- R8: The supported mask is {`feat_mask_hi`, `feat_mask_lo`}, with the high half in bits 63:32. A write that sets any bit outside this mask asserts `rsp_gp_fault` and leaves the enable register unchanged.
- R9: A write that passes every check stores the full 64-bit value, which the next read of index 0 returns. A write answers with zero data and no fault.
- R10: Each request sampled on a clock edge gives exactly one `rsp_done` pulse on the next cycle. `rsp_done` is never high in a cycle that did not follow a request. A fault output is never high without `rsp_done`.
- R11: At most one fault output is high at a time. The invalid-opcode check wins over every general-protection cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | 32 | Register index |
| req_wdata | input | 64 | Write value |
| os_enable | input | 1 | Operating-system enable for extended-state access |
| feat_mask_lo | input | 32 | Supported-component mask, bits 31:0 |
| feat_mask_hi | input | 32 | Supported-component mask, bits 63:32 |
| rsp_done | output | 1 | Completion pulse, one cycle after the request |
| rsp_rdata | output | 64 | Read result, zero on writes and on faults |
| rsp_ud_fault | output | 1 | Invalid-opcode fault |
| rsp_gp_fault | output | 1 | General-protection fault |

## Verification
The only internal state is the enable register, and a wrong value in it can be seen at the ports. It shows on the very next read of index 0 or 1. It also shows as a wrong fault on a later write whose outcome depends on it, so the bench reads the register back after every write that should have been rejected. The check ordering is exercised with requests that break several rules at once, where only the first rule in order may show. Pulse accounting is checked on every cycle by the scoreboard: a done pulse with no request outstanding is an error, and so is a request left unanswered.

// File: rtl/xcr_pkg.sv
package xcr_pkg;
  typedef enum logic [1:0] {
    VERD_OK = 2'd0,
    VERD_UD = 2'd1,
    VERD_GP = 2'd2
  } verdict_e;
endpackage

// File: rtl/xcr_check.sv
module xcr_check
  import xcr_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 32,
  parameter int HALF_W = 32
) (
  input  logic              is_write,
  input  logic [IDX_W-1:0]  index,
  input  logic [DATA_W-1:0] wdata,
  input  logic              os_en,
  input  logic [HALF_W-1:0] mask_lo,
  input  logic [HALF_W-1:0] mask_hi,
  output verdict_e          verdict,
  output logic              sel_inuse
);
  localparam int MASK_W = 2 * HALF_W;

  logic [MASK_W-1:0] supported;
  logic              idx_zero;
  logic              idx_one;

  assign supported = {mask_hi, mask_lo};
  assign idx_zero  = (index == '0);
  assign idx_one   = (index == IDX_W'(1));
  assign sel_inuse = idx_one;

  // Ordered screening: OS enable, then index, then x87 bit, then mask.
  always_comb begin
    verdict = VERD_OK;
    if (!os_en) begin
      verdict = VERD_UD;
    end else if (!is_write) begin
      if (!(idx_zero || idx_one)) verdict = VERD_GP;
    end else if (!idx_zero) begin
      verdict = VERD_GP;
    end else if (!wdata[0]) begin
      verdict = VERD_GP;
    end else if ((wdata & ~DATA_W'(supported)) != '0) begin
      verdict = VERD_GP;
    end
  end
endmodule

// File: rtl/xcr_state.sv
module xcr_state #(
  parameter int              DATA_W    = 64,
  parameter logic [DATA_W-1:0] RESET_VAL = 64'h1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= RESET_VAL;
    else if (wr_en) q <= wr_data;
  end
endmodule

// File: rtl/xcr_resp.sv
module xcr_resp
  import xcr_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic              is_write,
  input  verdict_e          verdict,
  input  logic [DATA_W-1:0] rd_value,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              ud,
  output logic              gp
);
  always_ff @(posedge clk) begin
    if (rst) begin
      done  <= 1'b0;
      rdata <= '0;
      ud    <= 1'b0;
      gp    <= 1'b0;
    end else begin
      done  <= valid;
      ud    <= valid && (verdict == VERD_UD);
      gp    <= valid && (verdict == VERD_GP);
      rdata <= (valid && !is_write && verdict == VERD_OK) ? rd_value : '0;
    end
  end

  // R11: exclusive faults
  a_r11_single_fault: assert property (@(posedge clk) disable iff (rst)
    $countones({ud, gp}) <= 1);
  // R10: no fault without done
  a_r10_fault_with_done: assert property (@(posedge clk) disable iff (rst)
    (ud || gp) |-> done);
endmodule

// File: rtl/xcr_access_unit.sv
module xcr_access_unit
  import xcr_pkg::*;
#(
  parameter int                DATA_W    = 64,
  parameter int                IDX_W     = 32,
  parameter int                HALF_W    = 32,
  parameter logic [DATA_W-1:0] RESET_VAL = 64'h1,
  parameter logic [DATA_W-1:0] INUSE_VEC = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [IDX_W-1:0]  req_index,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              os_enable,
  input  logic [HALF_W-1:0] feat_mask_lo,
  input  logic [HALF_W-1:0] feat_mask_hi,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_ud_fault,
  output logic              rsp_gp_fault
);
  verdict_e          verdict;
  logic              sel_inuse;
  logic              wr_en;
  logic [DATA_W-1:0] xcr_q;
  logic [DATA_W-1:0] rd_value;

  xcr_check #(.DATA_W(DATA_W), .IDX_W(IDX_W), .HALF_W(HALF_W)) u_check (
    .is_write (req_write),
    .index    (req_index),
    .wdata    (req_wdata),
    .os_en    (os_enable),
    .mask_lo  (feat_mask_lo),
    .mask_hi  (feat_mask_hi),
    .verdict  (verdict),
    .sel_inuse(sel_inuse)
  );

  assign wr_en    = req_valid && req_write && (verdict == VERD_OK);
  assign rd_value = sel_inuse ? (xcr_q & INUSE_VEC) : xcr_q;

  xcr_state #(.DATA_W(DATA_W), .RESET_VAL(RESET_VAL)) u_state (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_data(req_wdata),
    .q      (xcr_q)
  );

  xcr_resp #(.DATA_W(DATA_W)) u_resp (
    .clk     (clk),
    .rst     (rst),
    .valid   (req_valid),
    .is_write(req_write),
    .verdict (verdict),
    .rd_value(rd_value),
    .done    (rsp_done),
    .rdata   (rsp_rdata),
    .ud      (rsp_ud_fault),
    .gp      (rsp_gp_fault)
  );

  // R10: one done pulse per request, none otherwise
  a_r10_done_follows_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_done);
  a_r10_no_spurious_done: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_done);
  // R2: disabled OS gives invalid-opcode and leaves the register alone
  a_r2_ud_no_update: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !os_enable) |=> (rsp_ud_fault && $stable(xcr_q)));
  // R6: write to a nonzero index is rejected
  a_r6_bad_index_write: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && os_enable && req_index != '0)
      |=> (rsp_gp_fault && $stable(xcr_q)));
  // R7: x87 bit must stay set
  a_r7_x87_kept: assert property (@(posedge clk) disable iff (rst)
    xcr_q[0]);
endmodule

// File: tb/tb_xcr_access_unit.sv
module tb_xcr_access_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write, os_enable;
  logic [31:0] req_index, feat_mask_lo, feat_mask_hi;
  logic [63:0] req_wdata;
  logic        rsp_done, rsp_ud_fault, rsp_gp_fault;
  logic [63:0] rsp_rdata;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    logic [63:0] rdata;
    logic        ud;
    logic        gp;
    string       tag;
  } exp_t;
  exp_t sb[$];

  logic [63:0] model_xcr;

  always #5 clk = ~clk;

  xcr_access_unit dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_index(req_index), .req_wdata(req_wdata), .os_enable(os_enable),
    .feat_mask_lo(feat_mask_lo), .feat_mask_hi(feat_mask_hi),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .rsp_ud_fault(rsp_ud_fault), .rsp_gp_fault(rsp_gp_fault)
  );

  // Driver: drive on the falling edge, push the expected response.
  task automatic do_req(input logic wr, input logic [31:0] idx,
                        input logic [63:0] val, input logic os,
                        input logic [63:0] mask, input string tag);
    exp_t e;
    e.rdata = '0; e.ud = 1'b0; e.gp = 1'b0; e.tag = tag;
    if (!os) e.ud = 1'b1;
    else if (!wr) begin
      if (idx == 0) e.rdata = model_xcr;
      else if (idx == 1) e.rdata = model_xcr & 64'hFFFF_FFFF_FFFF_FFFF;
      else e.gp = 1'b1;
    end else if (idx != 0 || !val[0] || (val & ~mask) != 0) e.gp = 1'b1;
    else model_xcr = val;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_index = idx; req_wdata = val;
    os_enable = os; feat_mask_lo = mask[31:0]; feat_mask_hi = mask[63:32];
    sb.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: compare on falling edges.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && !finished) begin
        if (rsp_done) begin
          exp_t e;
          checks++;
          if (sb.size() == 0) begin
            failures++;
            $display("FAIL R10 done with no request: actual=1 expected=0");
          end else begin
            e = sb.pop_front();
            if (rsp_rdata !== e.rdata || rsp_ud_fault !== e.ud || rsp_gp_fault !== e.gp) begin
              failures++;
              $display("FAIL %s actual rdata=%h ud=%b gp=%b expected rdata=%h ud=%b gp=%b",
                       e.tag, rsp_rdata, rsp_ud_fault, rsp_gp_fault, e.rdata, e.ud, e.gp);
            end
          end
        end else if (rsp_ud_fault || rsp_gp_fault) begin
          checks++; failures++;
          $display("FAIL R10 fault without done: actual ud=%b gp=%b expected 0 0",
                   rsp_ud_fault, rsp_gp_fault);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  localparam logic [63:0] MASK = 64'h0000_0002_0000_0007;

  initial begin
    model_xcr = 64'h1;
    rst = 1'b1; req_valid = 0; req_write = 0; req_index = 0; req_wdata = 0;
    os_enable = 0; feat_mask_lo = 0; feat_mask_hi = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    checks++;
    if (rsp_done || rsp_ud_fault || rsp_gp_fault || rsp_rdata != 0) begin
      failures++;
      $display("FAIL R1 reset outputs actual=%b%b%b/%h expected=000/0",
               rsp_done, rsp_ud_fault, rsp_gp_fault, rsp_rdata);
    end
    do_req(0, 0, 0, 1, MASK, "R1 reset value");
    do_req(0, 1, 0, 1, MASK, "R4 in-use read");
    do_req(0, 2, 0, 1, MASK, "R5 read index 2");
    do_req(0, 32'hFFFF_FFFF, 0, 1, MASK, "R5 read high index");
    do_req(1, 0, 64'h3, 0, MASK, "R2 write os off");
    do_req(0, 0, 0, 1, MASK, "R2 unchanged after write");
    do_req(0, 7, 0, 0, MASK, "R11 os off beats bad index");
    do_req(1, 5, 64'h2, 0, MASK, "R11 os off beats all gp");
    do_req(1, 0, 64'h7, 1, MASK, "R9 legal write");
    do_req(0, 0, 0, 1, MASK, "R3 read back write");
    do_req(0, 1, 0, 1, MASK, "R4 in-use after write");
    do_req(1, 1, 64'h3, 1, MASK, "R6 write index 1");
    do_req(0, 0, 0, 1, MASK, "R6 unchanged");
    do_req(1, 0, 64'h6, 1, MASK, "R7 x87 cleared");
    do_req(0, 0, 0, 1, MASK, "R7 unchanged");
    do_req(1, 0, 64'h9, 1, MASK, "R8 low half outside mask");
    do_req(1, 0, 64'h0000_0001_0000_0001, 1, MASK, "R8 high half outside mask");
    do_req(0, 0, 0, 1, MASK, "R8 unchanged");
    do_req(1, 0, 64'h0000_0002_0000_0001, 1, MASK, "R8 high half inside mask");
    do_req(0, 0, 0, 1, MASK, "R9 full 64-bit stored");
    do_req(1, 0, 64'h1, 1, MASK, "R9 write minimum");
    do_req(0, 1, 0, 1, MASK, "R3 R4 after minimum");
    // R10: back-to-back requests, then idle
    begin
      exp_t e;
      @(negedge clk);
      req_valid = 1; req_write = 0; req_index = 0; os_enable = 1;
      e.rdata = model_xcr; e.ud = 0; e.gp = 0; e.tag = "R10 back-to-back a";
      sb.push_back(e);
      @(negedge clk);
      req_index = 3;
      e.rdata = 0; e.gp = 1; e.tag = "R10 back-to-back b";
      sb.push_back(e);
      @(negedge clk);
      req_valid = 0;
    end
    repeat (5) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      failures++;
      $display("FAIL R10 outstanding requests actual=%0d expected=0", sb.size());
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule